// File: doc/BRIEF.md
# Segmented DAC Input Decoder

This block is the digital front end of a 10-bit segmented current-steering converter. Each clock it takes a data word and an invert flag. When the flag is set it complements every bit except the top one, so a quarter-wave sine table can drive a full waveform and the top bit acts as the sign. The result is stored in a word register on the rising edge. The register sits directly in front of the current-cell controls, so all switches change together.

From the registered word the block derives two sets of cell controls. The low six bits go straight out as binary ladder controls. The high four bits are decoded into fifteen equal segment enables in thermometer code. A behavioural model turns the cell controls into two complementary output currents, counted in LSB units, for checking against the code.

The data path runs on every clock with no stall. A converter samples on every edge, so the inputs carry no handshake. The outputs follow the inputs with one cycle of latency.

Top module: `dacfe_core`

## Requirements
- R1: With `invert` low, the registered word equals `din` exactly.
- R2: With `invert` high, bits 0 to 8 of the registered word are the complement of `din` bits 0 to 8, and bit 9 equals `din` bit 9.
- R3: The word is captured only on the rising clock edge. A change of `din` or `invert` between edges leaves every output unchanged until the next rising edge.
- R4: A synchronous active-high `rst` clears the word register. After a reset edge, `ladder_bits` and `seg_en` are 0, `i_main` is 0 and `i_comp` is 1023.
- R5: `ladder_bits` equals bits 5:0 of the registered word.
- R6: `seg_en[k]`, for k from 0 to 14, is 1 exactly when bits 9:6 of the registered word, read as an unsigned number, are greater than k.
- R7: `i_main` equals 64 times the number of set bits of `seg_en`, plus `ladder_bits`. Code 0x3FF gives 1023, code 0x200 gives 512 and code 0x000 gives 0.
- R8: `i_comp` equals 1023 minus `i_main`, so the two model currents always sum to full scale less one LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Data word, bit 9 is the MSB |
| invert | input | 1 | Quadrature invert flag, sampled with `din` |
| ladder_bits | output | 6 | Binary ladder controls (registered bits 5:0) |
| seg_en | output | 15 | Thermometer segment enables for bits 9:6 |
| i_main | output | 10 | Model current on the true output, LSB units |
| i_comp | output | 10 | Model current on the complementary output, LSB units |

## Verification
Any wrong bit in the word register shows up one cycle after capture. A low bit appears as a wrong `ladder_bits` value. A high bit appears as the wrong number of segment enables. Both also shift `i_main` by a power of two. A decoder fault that leaves a gap in the thermometer pattern, or makes an enable disagree with the upper field, is visible in that same cycle as a wrong current. A register that ignores the clock edge is caught by the mid-cycle input change: the outputs move before the edge.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int DEF_DATA_W = 10;
  localparam int DEF_BIN_W  = 6;
endpackage

// File: rtl/dacfe_invert.sv
module dacfe_invert #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] d_in,
  input  logic              flip,
  output logic [DATA_W-1:0] d_out
);
  // sign bit passes straight through, magnitude bits complemented on flip
  assign d_out[DATA_W-1]   = d_in[DATA_W-1];
  assign d_out[DATA_W-2:0] = flip ? ~d_in[DATA_W-2:0] : d_in[DATA_W-2:0];
endmodule

// File: rtl/dacfe_therm.sv
module dacfe_therm #(
  parameter int UP_W  = 4,
  localparam int NSEG = (1 << UP_W) - 1
) (
  input  logic [UP_W-1:0] upper,
  output logic [NSEG-1:0] seg
);
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign seg[k] = (upper > UP_W'(k));
  end

  // R6: enables form a contiguous run from bit 0
  always_comb begin
    a_r6_therm_shape: assert (((seg + NSEG'(1)) & seg) == '0);
  end
endmodule

// File: rtl/dacfe_model.sv
module dacfe_model #(
  parameter int DATA_W = 10,
  parameter int BIN_W  = 6,
  localparam int NSEG  = (1 << (DATA_W - BIN_W)) - 1,
  localparam logic [DATA_W-1:0] FULL = {DATA_W{1'b1}}
) (
  input  logic [NSEG-1:0]   seg,
  input  logic [BIN_W-1:0]  lad,
  output logic [DATA_W-1:0] cur_main,
  output logic [DATA_W-1:0] cur_comp
);
  logic [DATA_W-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int k = 0; k < NSEG; k++) cnt = cnt + DATA_W'(seg[k]);
  end

  assign cur_main = (cnt << BIN_W) + DATA_W'(lad);
  assign cur_comp = FULL - cur_main;
endmodule

// File: rtl/dacfe_core.sv
module dacfe_core #(
  parameter int DATA_W = dacfe_pkg::DEF_DATA_W,
  parameter int BIN_W  = dacfe_pkg::DEF_BIN_W,
  localparam int UP_W  = DATA_W - BIN_W,
  localparam int NSEG  = (1 << UP_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              invert,
  output logic [BIN_W-1:0]  ladder_bits,
  output logic [NSEG-1:0]   seg_en,
  output logic [DATA_W-1:0] i_main,
  output logic [DATA_W-1:0] i_comp
);
  localparam logic [DATA_W-1:0] HALF = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] word_d, word_q;

  dacfe_invert #(.DATA_W(DATA_W)) u_inv (
    .d_in(din), .flip(invert), .d_out(word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_d;
  end

  assign ladder_bits = word_q[BIN_W-1:0];

  dacfe_therm #(.UP_W(UP_W)) u_therm (
    .upper(word_q[DATA_W-1:BIN_W]), .seg(seg_en)
  );

  dacfe_model #(.DATA_W(DATA_W), .BIN_W(BIN_W)) u_model (
    .seg(seg_en), .lad(ladder_bits), .cur_main(i_main), .cur_comp(i_comp)
  );

  // R4: reset edge gives zero current on the true output
  a_r4_reset_zero: assert property (@(posedge clk) rst |=> (i_main == '0));

  // R2: sign bit of the input selects the half of the range, invert or not
  a_r2_sign_half: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((i_main >= HALF) == $past(din[DATA_W-1])));

  // R7: segment count matches the upper field of the stored word
  a_r7_seg_count: assert property (@(posedge clk) disable iff (rst)
    $countones(seg_en) == int'(word_q[DATA_W-1:BIN_W]));

  // R7: model current equals the stored code
  a_r7_model_code: assert property (@(posedge clk) disable iff (rst)
    i_main == word_q);

  // R8: complementary pair sums to full scale minus one LSB
  a_r8_pair_sum: assert property (@(posedge clk) disable iff (rst)
    (DATA_W+1)'(i_main) + (DATA_W+1)'(i_comp) == (DATA_W+1)'((1 << DATA_W) - 1));
endmodule

// File: tb/dacfe_core_test.sv
module dacfe_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] din = '0;
  logic invert = 1'b0;
  logic [5:0] ladder_bits;
  logic [14:0] seg_en;
  logic [9:0] i_main, i_comp;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dacfe_core uut (
    .clk(clk), .rst(rst), .din(din), .invert(invert),
    .ladder_bits(ladder_bits), .seg_en(seg_en),
    .i_main(i_main), .i_comp(i_comp)
  );

  function automatic logic [9:0] ref_word(logic [9:0] d, logic inv);
    return inv ? {d[9], ~d[8:0]} : d;
  endfunction

  function automatic logic [14:0] ref_seg(logic [9:0] w);
    logic [14:0] s;
    for (int k = 0; k < 15; k++) s[k] = (int'(w[9:6]) > k);
    return s;
  endfunction

  function automatic int ref_main(logic [9:0] w);
    int n = 0;
    for (int k = 0; k < 15; k++) if (int'(w[9:6]) > k) n++;
    return n * 64 + int'(w[5:0]);
  endfunction

  task automatic check_word(logic [9:0] w, string tag);
    total++;
    if (ladder_bits !== w[5:0]) begin
      bad++; $display("FAIL %s R5 ladder act=%h exp=%h", tag, ladder_bits, w[5:0]);
    end
    total++;
    if (seg_en !== ref_seg(w)) begin
      bad++; $display("FAIL %s R6 seg act=%h exp=%h", tag, seg_en, ref_seg(w));
    end
    total++;
    if (int'(i_main) != ref_main(w)) begin
      bad++; $display("FAIL %s R7 main act=%0d exp=%0d", tag, i_main, ref_main(w));
    end
    total++;
    if (int'(i_comp) != 1023 - ref_main(w)) begin
      bad++; $display("FAIL %s R8 comp act=%0d exp=%0d", tag, i_comp, 1023 - ref_main(w));
    end
  endtask

  task automatic apply(logic [9:0] d, logic inv, string tag);
    din = d; invert = inv;
    @(posedge clk); @(negedge clk);
    check_word(ref_word(d, inv), tag);
  endtask

  task automatic expect_main(int exp, string tag);
    total++;
    if (int'(i_main) != exp) begin
      bad++; $display("FAIL %s act=%0d exp=%0d", tag, i_main, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); din = 10'h2A5; invert = 1'b1;
    @(posedge clk); @(negedge clk);
    check_word(10'h000, "R4 reset");
    rst = 1'b0;
    // R1 pass-through and R7 scale points
    apply(10'h3FF, 1'b0, "R1 full"); expect_main(1023, "R7 full scale");
    apply(10'h200, 1'b0, "R1 half"); expect_main(512, "R7 half scale");
    apply(10'h000, 1'b0, "R1 zero"); expect_main(0, "R7 zero");
    apply(10'h01F, 1'b0, "R1 low seg");
    apply(10'h3E0, 1'b0, "R1 high seg");
    apply(10'h040, 1'b0, "R6 one seg");
    apply(10'h3C0, 1'b0, "R6 all seg");
    // R2 inversion keeps the sign bit
    apply(10'h000, 1'b1, "R2 inv zero"); expect_main(511, "R2 inv zero code");
    apply(10'h3FF, 1'b1, "R2 inv full"); expect_main(512, "R2 inv full code");
    apply(10'h155, 1'b1, "R2 inv pattern");
    // R3 mid-cycle change has no effect before the edge
    apply(10'h123, 1'b0, "R3 base");
    din = 10'h2DC; invert = 1'b1;
    #1 check_word(10'h123, "R3 hold");
    @(posedge clk); @(negedge clk);
    check_word(ref_word(10'h2DC, 1'b1), "R3 capture");
    // R4 reset in the middle of traffic
    rst = 1'b1; din = 10'h3FF; invert = 1'b0;
    @(posedge clk); @(negedge clk);
    check_word(10'h000, "R4 mid reset");
    rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic [9:0] d = 10'($urandom);
      logic inv = 1'($urandom);
      apply(d, inv, inv ? "R2 rand" : "R1 rand");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R3 act=hung exp=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule